// File: doc/BRIEF.md
# Reset Cause Status Register

This block is an 8-bit control and status register that tells firmware why the device last came out of reset. It also holds two control bits. Single-cycle event strobes clear the status flags. The strobes come from the reset generator, the brown-out detector, the watchdog, and the CPU's sleep, watchdog-clear and reset instructions. Firmware reads the whole register through a plain read/write port and sets the flags back to 1 so that the next event can be detected. All flags are active-low: 0 means "this happened".

A 2-bit brown-out configuration field sets whether software may enable brown-out detection. Only configuration `01` lets the software enable bit take a write, reach its output and read back. In every other configuration the bit reads as 0. The interrupt priority enable bit is a plain firmware bit that is driven out to the interrupt controller. When the brown-out flag reads 0 and the power-on flag reads 1, a brown-out reset is the cause, provided firmware set the power-on flag after the earlier power-on.

Top module: `rst_cause_reg`

## Requirements
- R1: The read word has this layout, from bit 7 to bit 0: priority enable, software brown-out enable, configuration mismatch, reset instruction, watchdog time-out, power-down, power-on, brown-out. After an asynchronous reset it reads 0x7C with `bor_cfg`=01 and 0x3C otherwise.
- R2: `evt_por` takes precedence over every other event and any write in the same cycle. It loads the power-on image 0x7C, with bit 6 gated as in R8.
- R3: `evt_bor`, `evt_reset_instr`, `evt_cfg_mismatch` and `evt_por` clear bits 0, 4, 5 and 1 respectively. A non-power-on event changes no other bit.
- R4: A write (`wr_en`=1) loads bits 7, 5, 4, 1 and 0 from `wr_data`. If a clearing event hits a flag in the same cycle, the flag becomes 0.
- R5: The watchdog time-out flag (bit 3) goes to 0 on `evt_wdt_timeout`. It goes to 1 on `evt_sleep` or `evt_wdt_clear`. A time-out wins over a simultaneous sleep or clear.
- R6: The power-down flag (bit 2) goes to 0 on `evt_sleep` and to 1 on `evt_wdt_clear`. Sleep wins over a simultaneous clear.
- R7: Writes have no effect on bits 3 and 2.
- R8: The software brown-out enable bit is written only while `bor_cfg`=01. While `bor_cfg` is not 01, it reads 0 and `sw_bor_en` is 0. The stored value reappears when `bor_cfg` returns to 01.
- R9: `prio_en` equals register bit 7.
- R10: After firmware has set bits 1 and 0 to 1, a brown-out event makes `rd_data[1:0]` read 2'b10.
- R11: Events and writes take effect at the next rising clock edge. `rd_data` does not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the power-on image |
| evt_por | input | 1 | Power-on event strobe |
| evt_bor | input | 1 | Brown-out reset event strobe |
| evt_wdt_timeout | input | 1 | Watchdog time-out strobe |
| evt_sleep | input | 1 | Sleep instruction strobe |
| evt_wdt_clear | input | 1 | Watchdog-clear instruction strobe |
| evt_reset_instr | input | 1 | Software reset instruction strobe |
| evt_cfg_mismatch | input | 1 | Configuration mismatch reset strobe |
| bor_cfg | input | 2 | Brown-out configuration field |
| wr_en | input | 1 | Register write enable |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value (combinational) |
| prio_en | output | 1 | Interrupt priority enable |
| sw_bor_en | output | 1 | Gated software brown-out enable |

## Verification
The bench targets the cycles in which a clearing event and a firmware write to the same flag coincide. A design that let the write win would lose the record of a reset. It also drives time-out together with sleep, and sleep together with watchdog clear. A wrong precedence here would report the watchdog or power-down state backwards. Power-on is applied with other events and a write in the same cycle, which shows whether any bit escapes the power-on image. The configuration field is moved away from 01 and back, which exposes a design that lets writes through while gated or forgets the stored enable bit.

// File: rtl/rst_cause_pkg.sv
`timescale 1ns/1ps
package rst_cause_pkg;
  localparam int REG_W     = 8;
  localparam int BOR_CFG_W = 2;

  localparam int IDX_PRIO = 7;
  localparam int IDX_SBOR = 6;
  localparam int IDX_CM   = 5;
  localparam int IDX_RI   = 4;
  localparam int IDX_TO   = 3;
  localparam int IDX_PD   = 2;
  localparam int IDX_POR  = 1;
  localparam int IDX_BOR  = 0;

  localparam logic [BOR_CFG_W-1:0] BOR_CFG_SW     = 2'b01;
  localparam logic [REG_W-1:0]     POWER_ON_IMAGE = 8'b0111_1100;

  typedef struct packed {
    logic prio;
    logic sbor;
    logic cm;
    logic ri;
    logic to;
    logic pd;
    logic por;
    logic bor;
  } cause_bits_t;

  // Software brown-out control is honoured in one configuration only
  function automatic logic sw_bor_allowed(input logic [BOR_CFG_W-1:0] cfg);
    return (cfg == BOR_CFG_SW);
  endfunction

  // Assemble the visible word, masking the enable bit when gated
  function automatic logic [REG_W-1:0] pack_read(input cause_bits_t s,
                                                 input logic allow);
    cause_bits_t v;
    v      = s;
    v.sbor = s.sbor & allow;
    return v;
  endfunction
endpackage

// File: rtl/rcs_flag_cell.sv
`timescale 1ns/1ps
// Event-cleared, firmware-written status bit
module rcs_flag_cell #(
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_por,
  input  logic hw_clr,
  input  logic fw_we,
  input  logic fw_d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= INIT;
    else if (load_por) q <= INIT;
    else if (hw_clr)   q <= 1'b0;
    else if (fw_we)    q <= fw_d;
  end
endmodule

// File: rtl/rcs_power_state.sv
`timescale 1ns/1ps
// Watchdog time-out and power-down flags: hardware-only state
module rcs_power_state (
  input  logic clk,
  input  logic rst_n,
  input  logic load_por,
  input  logic wdt_timeout,
  input  logic sleep_exec,
  input  logic wdt_clear,
  output logic to_q,
  output logic pd_q
);
  logic to_set, to_clr, pd_set, pd_clr;

  assign to_clr = wdt_timeout;
  assign to_set = (sleep_exec | wdt_clear) & ~wdt_timeout;
  assign pd_clr = sleep_exec;
  assign pd_set = wdt_clear & ~sleep_exec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else if (load_por) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else begin
      if (to_clr)      to_q <= 1'b0;
      else if (to_set) to_q <= 1'b1;
      if (pd_clr)      pd_q <= 1'b0;
      else if (pd_set) pd_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rcs_bor_enable.sv
`timescale 1ns/1ps
// Software brown-out enable, gated by the configuration field
module rcs_bor_enable
  import rst_cause_pkg::*;
#(
  parameter logic INIT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_por,
  input  logic [BOR_CFG_W-1:0] cfg,
  input  logic                 fw_we,
  input  logic                 fw_d,
  output logic                 stored_q,
  output logic                 allow
);
  assign allow = sw_bor_allowed(cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                stored_q <= INIT;
    else if (load_por)         stored_q <= INIT;
    else if (fw_we && allow)   stored_q <= fw_d;
  end
endmodule

// File: rtl/rst_cause_reg.sv
`timescale 1ns/1ps
module rst_cause_reg
  import rst_cause_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_por,
  input  logic                 evt_bor,
  input  logic                 evt_wdt_timeout,
  input  logic                 evt_sleep,
  input  logic                 evt_wdt_clear,
  input  logic                 evt_reset_instr,
  input  logic                 evt_cfg_mismatch,
  input  logic [BOR_CFG_W-1:0] bor_cfg,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wr_data,
  output logic [REG_W-1:0]     rd_data,
  output logic                 prio_en,
  output logic                 sw_bor_en
);
  // Firmware-writable flags: brown-out, power-on, reset-instr, mismatch, priority
  localparam int FW_N = 5;
  localparam int FW_POS [FW_N] = '{IDX_BOR, IDX_POR, IDX_RI, IDX_CM, IDX_PRIO};

  // Named internal events
  logic              por_load;
  logic [FW_N-1:0]   fw_clr;
  logic [FW_N-1:0]   fw_q;
  logic              to_q, pd_q, sbor_q, sbor_allow;
  logic              unused_ro_bits;
  cause_bits_t       state;

  assign por_load = evt_por;
  assign fw_clr   = {1'b0, evt_cfg_mismatch, evt_reset_instr, 1'b0, evt_bor};
  assign unused_ro_bits = &{1'b0, wr_data[IDX_TO], wr_data[IDX_PD]};

  for (genvar g = 0; g < FW_N; g++) begin : g_fw
    rcs_flag_cell #(.INIT(POWER_ON_IMAGE[FW_POS[g]])) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_por (por_load),
      .hw_clr   (fw_clr[g]),
      .fw_we    (wr_en),
      .fw_d     (wr_data[FW_POS[g]]),
      .q        (fw_q[g])
    );
  end

  rcs_power_state u_pwr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_por    (por_load),
    .wdt_timeout (evt_wdt_timeout),
    .sleep_exec  (evt_sleep),
    .wdt_clear   (evt_wdt_clear),
    .to_q        (to_q),
    .pd_q        (pd_q)
  );

  rcs_bor_enable #(.INIT(POWER_ON_IMAGE[IDX_SBOR])) u_sbor (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_por (por_load),
    .cfg      (bor_cfg),
    .fw_we    (wr_en),
    .fw_d     (wr_data[IDX_SBOR]),
    .stored_q (sbor_q),
    .allow    (sbor_allow)
  );

  always_comb begin
    state      = '0;
    state.bor  = fw_q[0];
    state.por  = fw_q[1];
    state.ri   = fw_q[2];
    state.cm   = fw_q[3];
    state.prio = fw_q[4];
    state.to   = to_q;
    state.pd   = pd_q;
    state.sbor = sbor_q;
  end

  assign rd_data   = pack_read(state, sbor_allow);
  assign prio_en   = state.prio;
  assign sw_bor_en = sbor_q & sbor_allow;
endmodule

// File: rtl/rcs_checker.sv
`timescale 1ns/1ps
module rcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_por,
  input logic       evt_bor,
  input logic       evt_wdt_timeout,
  input logic       evt_sleep,
  input logic       evt_wdt_clear,
  input logic [1:0] bor_cfg,
  input logic       wr_en,
  input logic [7:0] rd_data,
  input logic       sw_bor_en
);
  assert_por_image_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_por |=> ({rd_data[7], rd_data[5:0]} == 7'b0111100));

  assert_hw_beats_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_bor && wr_en && !evt_por) |=> !rd_data[0]);

  assert_timeout_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wdt_timeout && !evt_por) |=> !rd_data[3]);

  assert_sleep_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_sleep && !evt_por) |=> !rd_data[2]);

  assert_ro_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !evt_por && !evt_wdt_timeout && !evt_sleep && !evt_wdt_clear)
      |=> (rd_data[3:2] == $past(rd_data[3:2])));

  assert_gated_sbor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_cfg != 2'b01) |-> (!rd_data[6] && !sw_bor_en));
endmodule

bind rst_cause_reg rcs_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .evt_por         (evt_por),
  .evt_bor         (evt_bor),
  .evt_wdt_timeout (evt_wdt_timeout),
  .evt_sleep       (evt_sleep),
  .evt_wdt_clear   (evt_wdt_clear),
  .bor_cfg         (bor_cfg),
  .wr_en           (wr_en),
  .rd_data         (rd_data),
  .sw_bor_en       (sw_bor_en)
);

// File: tb/rst_cause_reg_test.sv
`timescale 1ns/1ps
module rst_cause_reg_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_por = 0, evt_bor = 0, evt_wdt_timeout = 0, evt_sleep = 0;
  logic       evt_wdt_clear = 0, evt_reset_instr = 0, evt_cfg_mismatch = 0;
  logic [1:0] bor_cfg = 2'b01;
  logic       wr_en = 0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       prio_en, sw_bor_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rst_cause_reg uut (
    .clk(clk), .rst_n(rst_n), .evt_por(evt_por), .evt_bor(evt_bor),
    .evt_wdt_timeout(evt_wdt_timeout), .evt_sleep(evt_sleep),
    .evt_wdt_clear(evt_wdt_clear), .evt_reset_instr(evt_reset_instr),
    .evt_cfg_mismatch(evt_cfg_mismatch), .bor_cfg(bor_cfg), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .prio_en(prio_en),
    .sw_bor_en(sw_bor_en)
  );

  // Behavioural reference: one integer per bit
  int m_ip, m_sb, m_cm, m_ri, m_to, m_pd, m_po, m_bo;

  function automatic int expected_word();
    int sb_vis;
    sb_vis = (bor_cfg == 2'b01) ? m_sb : 0;
    return m_ip*128 + sb_vis*64 + m_cm*32 + m_ri*16 + m_to*8 + m_pd*4 + m_po*2 + m_bo;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || evt_por) begin
      m_ip = 0; m_sb = 1; m_cm = 1; m_ri = 1; m_to = 1; m_pd = 1; m_po = 0; m_bo = 0;
    end else begin
      if (wr_en) begin
        m_ip = wr_data[7]; m_cm = wr_data[5]; m_ri = wr_data[4];
        m_po = wr_data[1]; m_bo = wr_data[0];
        if (bor_cfg == 2'b01) m_sb = wr_data[6];
      end
      if (evt_bor)          m_bo = 0;
      if (evt_reset_instr)  m_ri = 0;
      if (evt_cfg_mismatch) m_cm = 0;
      if (evt_wdt_clear) begin m_to = 1; m_pd = 1; end
      if (evt_sleep)       begin m_to = 1; m_pd = 0; end
      if (evt_wdt_timeout) m_to = 0;
    end
  end

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, actual, expected);
    end
  endtask

  // Continuous comparison of the whole register (R1) and its outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 model word", rd_data, expected_word());
      check("R9 prio_en", prio_en, m_ip);
      check("R8 sw_bor_en", sw_bor_en, (bor_cfg == 2'b01) ? m_sb : 0);
    end
  end

  task automatic clear_inputs();
    evt_por = 0; evt_bor = 0; evt_wdt_timeout = 0; evt_sleep = 0;
    evt_wdt_clear = 0; evt_reset_instr = 0; evt_cfg_mismatch = 0; wr_en = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic write(input logic [7:0] d);
    wr_en = 1; wr_data = d; tick();
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset image cfg01", rd_data, 8'h7C);
    bor_cfg = 2'b00; #1;
    check("R1 reset image cfg00", rd_data, 8'h3C);
    check("R8 gated enable", sw_bor_en, 0);
    bor_cfg = 2'b01;
    rst_n = 1;
    @(negedge clk);

    write(8'h00);
    check("R7 read-only bits after zero write", rd_data, 8'h0C);
    check("R9 prio low", prio_en, 0);
    write(8'h80);
    check("R9 prio high", prio_en, 1);
    write(8'hF3);
    check("R4 firmware set", rd_data, 8'hFF);

    bor_cfg = 2'b10; wr_en = 1; wr_data = 8'hB3; tick();
    check("R8 gated read", rd_data, 8'hBF);
    bor_cfg = 2'b01; #1;
    check("R8 stored value kept", rd_data, 8'hFF);

    wr_en = 1; wr_data = 8'h3F; #1;
    check("R11 no change before edge", rd_data, 8'hFF);
    tick();
    check("R11 write at edge", rd_data, 8'h3F);
    write(8'hFF);

    evt_bor = 1; tick();
    check("R3 brown-out only bit0", rd_data, 8'hFE);
    check("R10 brown-out signature", rd_data[1:0], 2'b10);
    write(8'hFF);
    evt_reset_instr = 1; tick();
    check("R3 reset instr", rd_data, 8'hEF);
    evt_cfg_mismatch = 1; tick();
    check("R3 mismatch", rd_data, 8'hCF);
    write(8'hFF);
    evt_bor = 1; wr_en = 1; wr_data = 8'hFF; tick();
    check("R4 hardware beats write", rd_data, 8'hFE);
    write(8'hFF);

    evt_wdt_timeout = 1; tick();
    check("R5 timeout", rd_data, 8'hF7);
    evt_wdt_clear = 1; tick();
    check("R5 clear sets", rd_data, 8'hFF);
    evt_sleep = 1; tick();
    check("R6 sleep", rd_data, 8'hFB);
    evt_wdt_clear = 1; tick();
    check("R6 clear sets", rd_data, 8'hFF);
    evt_wdt_timeout = 1; evt_sleep = 1; tick();
    check("R5 timeout beats sleep", rd_data, 8'hF3);
    evt_wdt_clear = 1; evt_sleep = 1; tick();
    check("R6 sleep beats clear", rd_data, 8'hFB);
    evt_wdt_timeout = 1; tick();
    wr_en = 1; wr_data = 8'hFF; tick();
    check("R7 write ignored on TO/PD", rd_data[3:2], 2'b00);

    evt_por = 1; evt_bor = 1; evt_wdt_timeout = 1; wr_en = 1; wr_data = 8'hFF; tick();
    check("R2 power-on wins", rd_data, 8'h7C);
    check("R2 prio cleared", prio_en, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule